// File: doc/BRIEF.md
# Host Bus Port Mode Detection and Address Decode

This block is the front end of a parallel host port. It accepts either a non-multiplexed bus, with separate 8-bit address and 16-bit data lines, or a multiplexed bus. On the multiplexed bus the low address byte arrives on the data lines and an address-latch strobe captures it. When the multiplexed bus is in use, the block works out the bus timing flavour by itself: it samples the strobe line on the rising edge of the address-latch signal.

Each access is decoded into one of two targets. The first is a small register file: the interface mode register, the control register, a read-only frame alignment value and a frame offset register. The second is a 32-channel window into an external data or connection memory. The control register chooses which memory and which stream section the window points at. The block handles read-only locations and unmapped addresses, returns a transfer acknowledge, and produces the enable for the serial output drivers.

All inputs are taken as synchronous to `clk`. Each access is performed exactly once, on the first cycle in which chip select and the active strobe are both present.

Top module: `host_port_decode`

## Requirements
- R1: With `bus_muxed` low the address is taken from `addr_in`. An access is active while `cs_n` is low and `strb_n` is low, and `rw_n` high means read and low means write. `ale` has no effect.
- R2: With `bus_muxed` high, a rising edge of `ale` latches `wdata[7:0]` as the address and samples `strb_n`. Low selects timing mode 1 (`bus_mode` = 1) and high selects timing mode 2 (`bus_mode` = 2). `bus_mode` is 0 while `bus_muxed` is low.
- R3: In mode 1 the strobe is active high on `strb_n`, and `rw_n` selects read (1) or write (0). In mode 2 `strb_n` low is a read strobe and `rw_n` low is a write strobe.
- R4: Addresses with bit 7 clear select registers by offset: 0 is the mode register, 1 is the control register, 2 is the frame alignment value and 3 is the frame offset register. Every other offset reads as zero and ignores writes.
- R5: Addresses of the form 100xxxxx pulse `mem_req` in the access cycle, with `mem_chan` set to address bits 4:0, `mem_stream` set to control bits 3:0 and `mem_conn` set to control bit 4 (1 selects connection memory). Reads return `mem_rdata`. Addresses with bit 7 set and bit 6 or bit 5 set are unmapped: they read as zero and raise no `mem_req`.
- R6: The frame alignment offset reads `far_value`, and writes to it are ignored. When control bit 4 is 0 (data memory), a memory write raises `mem_req` but never `mem_we`.
- R7: `xfer_ack` rises one clock after an access becomes active, stays high while it is held, and falls one clock after it is released. A held access is performed once.
- R8: `drv_en` is 1 whenever `drv_force` is high. Otherwise it follows bit 0 of the mode register.
- R9: After reset all registers, `rdata` and `xfer_ack` are zero, and the multiplexed timing mode is mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_muxed | input | 1 | High selects the multiplexed bus |
| cs_n | input | 1 | Chip select, active low |
| strb_n | input | 1 | Data strobe / read strobe line |
| rw_n | input | 1 | Read-write select / write strobe line |
| ale | input | 1 | Address latch strobe (multiplexed bus) |
| addr_in | input | 8 | Address (non-multiplexed bus) |
| wdata | input | 16 | Write data; low byte carries the address on the multiplexed bus |
| rdata | output | 16 | Read data, valid while `xfer_ack` is high |
| xfer_ack | output | 1 | Transfer acknowledge |
| bus_mode | output | 2 | 0 non-multiplexed, 1 mode 1, 2 mode 2 |
| far_value | input | 16 | Frame alignment value to report |
| mem_req | output | 1 | Memory access pulse |
| mem_we | output | 1 | Memory write qualifier |
| mem_conn | output | 1 | 1 connection memory, 0 data memory |
| mem_stream | output | 4 | Stream section select |
| mem_chan | output | 5 | Channel location |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| drv_force | input | 1 | Forces the serial output drivers on |
| drv_en | output | 1 | Serial output driver enable |
| ims_reg | output | 16 | Interface mode register |
| ctrl_reg | output | 16 | Control register |
| foff_reg | output | 16 | Frame offset register |

## Verification
The bench builds the block with its default parameters: a 16-bit data path and a 4-bit stream select, which puts the memory select at control bit 4. With these values every register offset and the full 32-channel memory window can be reached, and so can the unmapped space both below and above that window. The bench drives all three bus flavours through the same directed access task. This exercises the automatic choice between mode 1 and mode 2, the read-only and unmapped paths, and a strobe held for several cycles.

// File: rtl/host_port_decode.sv
module host_port_decode #(
  parameter int DW    = 16,
  parameter int STA_W = 4,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_muxed,
  input  logic             cs_n,
  input  logic             strb_n,
  input  logic             rw_n,
  input  logic             ale,
  input  logic [AW-1:0]    addr_in,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             xfer_ack,
  output logic [1:0]       bus_mode,
  input  logic [DW-1:0]    far_value,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_conn,
  output logic [STA_W-1:0] mem_stream,
  output logic [AW-4:0]    mem_chan,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             drv_force,
  output logic             drv_en,
  output logic [DW-1:0]    ims_reg,
  output logic [DW-1:0]    ctrl_reg,
  output logic [DW-1:0]    foff_reg
);
  localparam int OW = AW - 1;
  localparam logic [OW-1:0] OFF_IMS  = OW'(0);
  localparam logic [OW-1:0] OFF_CTRL = OW'(1);
  localparam logic [OW-1:0] OFF_FAR  = OW'(2);
  localparam logic [OW-1:0] OFF_FOFF = OW'(3);

  logic          ale_q, act_q, mode2_q;
  logic [AW-1:0] addr_q, cur_addr;
  logic          strobe, act, start, wr, reg_hit, mem_hit;
  logic [DW-1:0] rd_val;

  assign cur_addr = bus_muxed ? addr_q : addr_in;
  assign bus_mode = bus_muxed ? (mode2_q ? 2'd2 : 2'd1) : 2'd0;
  assign wr       = !rw_n;

  always_comb begin
    if (!bus_muxed)   strobe = !strb_n;
    else if (mode2_q) strobe = !strb_n || !rw_n;
    else              strobe = strb_n;
  end

  assign act     = !cs_n && strobe;
  assign start   = act && !act_q;
  assign reg_hit = !cur_addr[AW-1];
  assign mem_hit = cur_addr[AW-1:AW-3] == 3'b100;

  assign mem_conn   = ctrl_reg[STA_W];
  assign mem_stream = ctrl_reg[STA_W-1:0];
  assign mem_chan   = cur_addr[AW-4:0];
  assign mem_wdata  = wdata;
  assign mem_req    = start && mem_hit;
  assign mem_we     = mem_req && wr && mem_conn;
  assign drv_en     = drv_force || ims_reg[0];

  always_comb begin
    rd_val = '0;
    if (reg_hit) begin
      case (cur_addr[OW-1:0])
        OFF_IMS:  rd_val = ims_reg;
        OFF_CTRL: rd_val = ctrl_reg;
        OFF_FAR:  rd_val = far_value;
        OFF_FOFF: rd_val = foff_reg;
        default:  rd_val = '0;
      endcase
    end else if (mem_hit) begin
      rd_val = mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q    <= 1'b0;
      act_q    <= 1'b0;
      mode2_q  <= 1'b0;
      addr_q   <= '0;
      xfer_ack <= 1'b0;
      rdata    <= '0;
      ims_reg  <= '0;
      ctrl_reg <= '0;
      foff_reg <= '0;
    end else begin
      ale_q    <= ale;
      act_q    <= act;
      xfer_ack <= act;
      if (bus_muxed && ale && !ale_q) begin
        addr_q  <= wdata[AW-1:0];
        mode2_q <= strb_n;
      end
      if (start) begin
        if (!wr) rdata <= rd_val;
        else if (reg_hit) begin
          case (cur_addr[OW-1:0])
            OFF_IMS:  ims_reg  <= wdata;
            OFF_CTRL: ctrl_reg <= wdata;
            OFF_FOFF: foff_reg <= wdata;
            default:  ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/host_port_decode_chk.sv
module host_port_decode_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_muxed,
  input logic          ale,
  input logic          strb_n,
  input logic          start,
  input logic          xfer_ack,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_conn,
  input logic [AW-4:0] mem_chan,
  input logic [AW-1:0] cur_addr,
  input logic          drv_force,
  input logic          drv_en,
  input logic [1:0]    bus_mode
);
  assert_mode_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_muxed && $rose(ale)) |=> (bus_mode == ($past(strb_n) ? 2'd2 : 2'd1)));

  assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (cur_addr[AW-1:AW-3] == 3'b100 && mem_chan == cur_addr[AW-4:0]));

  assert_dm_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && mem_conn));

  assert_ack_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> xfer_ack);

  assert_single_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> !start);

  assert_force_drv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_force |-> drv_en);
endmodule

bind host_port_decode host_port_decode_chk #(.AW(AW)) u_chk (.*);

// File: tb/host_port_decode_tb.sv
module host_port_decode_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_muxed = 1'b0, cs_n = 1'b1, strb_n = 1'b1, rw_n = 1'b1, ale = 1'b0;
  logic [7:0] addr_in = '0;
  logic [15:0] wdata = '0, rdata, far_value = 16'h5A5A, mem_wdata, mem_rdata;
  logic [15:0] ims_reg, ctrl_reg, foff_reg;
  logic xfer_ack, mem_req, mem_we, mem_conn, drv_force = 1'b0, drv_en;
  logic [1:0] bus_mode;
  logic [3:0] mem_stream;
  logic [4:0] mem_chan;

  int total = 0, fails = 0;
  bit done = 1'b0;
  int mode = 0;
  logic [15:0] last_rd;
  logic last_req, last_we, last_conn;
  logic [3:0] last_stream;
  logic [4:0] last_chan;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = {3'b101, mem_conn, mem_stream, 3'b000, mem_chan};

  host_port_decode u_dut (.*);

  function automatic logic [15:0] exp_mem(logic c, logic [3:0] s, logic [4:0] ch);
    return {3'b101, c, s, 3'b000, ch};
  endfunction

  task automatic chk(string req, logic [15:0] actual, logic [15:0] expected);
    total++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  task automatic idle_lines();
    cs_n = 1'b1;
    rw_n = 1'b1;
    strb_n = (bus_muxed && mode == 1) ? 1'b0 : 1'b1;
  endtask

  task automatic drive_active(bit wr, logic [7:0] a, logic [15:0] d);
    cs_n = 1'b0;
    wdata = d;
    if (mode == 0) begin strb_n = 1'b0; rw_n = !wr; addr_in = a; end
    else if (mode == 1) begin strb_n = 1'b1; rw_n = !wr; end
    else if (wr) rw_n = 1'b0;
    else strb_n = 1'b0;
  endtask

  task automatic access(bit wr, logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    drive_active(wr, a, d);
    #1;
    last_req = mem_req; last_we = mem_we; last_conn = mem_conn;
    last_stream = mem_stream; last_chan = mem_chan;
    chk("R7 ack low before edge", 16'(xfer_ack), 16'h0);
    @(negedge clk);
    chk("R7 ack high", 16'(xfer_ack), 16'h1);
    last_rd = rdata;
    idle_lines();
    @(negedge clk);
    chk("R7 ack released", 16'(xfer_ack), 16'h0);
  endtask

  task automatic ale_pulse(logic [7:0] a, logic lvl);
    @(negedge clk);
    wdata = {8'h00, a}; strb_n = lvl; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 ack", 16'(xfer_ack), 16'h0);
    chk("R9 rdata", rdata, 16'h0);
    chk("R9 ims", ims_reg, 16'h0);
    chk("R9 ctrl", ctrl_reg, 16'h0);
    chk("R9 foff", foff_reg, 16'h0);
    chk("R8 drv off after reset", 16'(drv_en), 16'h0);
    chk("R2 mode nonmux", 16'(bus_mode), 16'h0);
  endtask

  task automatic t_regs();
    mode = 0; bus_muxed = 1'b0;
    access(1, 8'h00, 16'h1235); access(0, 8'h00, 0);
    chk("R4 ims readback", last_rd, 16'h1235);
    chk("R8 drv follows ims bit0", 16'(drv_en), 16'h1);
    access(1, 8'h01, 16'h0013); access(0, 8'h01, 0);
    chk("R4 ctrl readback", last_rd, 16'h0013);
    access(1, 8'h03, 16'hBEEF); access(0, 8'h03, 0);
    chk("R4 foff readback", last_rd, 16'hBEEF);
    access(1, 8'h02, 16'hFFFF); access(0, 8'h02, 0);
    chk("R6 far read-only", last_rd, 16'h5A5A);
    access(1, 8'h10, 16'hFFFF); access(0, 8'h10, 0);
    chk("R4 unmapped reads zero", last_rd, 16'h0);
    chk("R4 unmapped write ignored ims", ims_reg, 16'h1235);
    chk("R4 unmapped write ignored foff", foff_reg, 16'hBEEF);
    @(negedge clk); ale = 1'b1; wdata = 16'h0003; @(negedge clk); ale = 1'b0;
    access(0, 8'h00, 0);
    chk("R1 ale ignored in nonmux", last_rd, 16'h1235);
    access(1, 8'h00, 16'h0000);
    chk("R8 drv off", 16'(drv_en), 16'h0);
    drv_force = 1'b1; #1;
    chk("R8 drv forced", 16'(drv_en), 16'h1);
    drv_force = 1'b0;
  endtask

  task automatic t_memory();
    mode = 0; bus_muxed = 1'b0;
    access(1, 8'h01, 16'h0015);
    access(1, 8'h87, 16'h1111);
    chk("R5 req on write", 16'(last_req), 16'h1);
    chk("R5 we conn", 16'(last_we), 16'h1);
    chk("R5 chan", 16'(last_chan), 16'd7);
    chk("R5 stream", 16'(last_stream), 16'd5);
    chk("R5 conn sel", 16'(last_conn), 16'h1);
    access(0, 8'h87, 0);
    chk("R5 mem read", last_rd, exp_mem(1'b1, 4'd5, 5'd7));
    access(1, 8'h01, 16'h0002);
    access(1, 8'h9F, 16'h2222);
    chk("R6 dm write req", 16'(last_req), 16'h1);
    chk("R6 dm write no we", 16'(last_we), 16'h0);
    access(0, 8'h9F, 0);
    chk("R6 dm read", last_rd, exp_mem(1'b0, 4'd2, 5'd31));
    access(0, 8'hA3, 0);
    chk("R5 unmapped high no req", 16'(last_req), 16'h0);
    chk("R5 unmapped high zero", last_rd, 16'h0);
  endtask

  task automatic t_mux1();
    bus_muxed = 1'b1; mode = 1; idle_lines();
    ale_pulse(8'h01, 1'b0);
    @(negedge clk);
    chk("R2 mode1 detected", 16'(bus_mode), 16'd1);
    access(1, 8'h00, 16'h0004);
    ale_pulse(8'h01, 1'b0);
    access(0, 8'h00, 0);
    chk("R3 mode1 ctrl readback", last_rd, 16'h0004);
    ale_pulse(8'h8C, 1'b0);
    access(0, 8'h00, 0);
    chk("R2 latched mem address", last_rd, exp_mem(1'b0, 4'd4, 5'd12));
  endtask

  task automatic t_mux2();
    bus_muxed = 1'b1; mode = 2; idle_lines();
    ale_pulse(8'h03, 1'b1);
    @(negedge clk);
    chk("R2 mode2 detected", 16'(bus_mode), 16'd2);
    access(1, 8'h00, 16'h0077);
    access(0, 8'h00, 0);
    chk("R3 mode2 foff readback", last_rd, 16'h0077);
    chk("R3 mode2 foff reg", foff_reg, 16'h0077);
  endtask

  task automatic t_hold();
    bus_muxed = 1'b0; mode = 0; idle_lines();
    @(negedge clk);
    drive_active(0, 8'h85, 0);
    #1 chk("R7 first req", 16'(mem_req), 16'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 ack held", 16'(xfer_ack), 16'h1);
      #1 chk("R7 no repeat req", 16'(mem_req), 16'h0);
    end
    chk("R7 held read data", rdata, exp_mem(1'b0, 4'd4, 5'd5));
    idle_lines();
    @(negedge clk);
    chk("R7 ack drops", 16'(xfer_ack), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_memory();
    t_mux1();
    t_mux2();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog R7 actual=timeout expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule